// File: doc/BRIEF.md
# Chained Serial Configuration Port

This block is the serial slave port of one monitor in a vertical chain of identical devices. The host talks only to the bottom device through a four-wire port: chip select, clock, data in and data out. Each device repeats chip select and clock straight up to the device above. It forwards data upward on its own data line, and it receives the upper device's data out on a return line. The clock idles high, and every device samples input data on the rising clock edge and changes its outputs on the falling edge. All pins are sampled into the core clock domain through a short synchronizer, so the serial clock must run well below the core clock.

A frame opens with an eight-bit command, most significant bit first. A configuration write carries six bytes for every device in the chain, top device first. Each device keeps the last 48 bits it sees. Everything older is passed upward with a fixed 48-bit delay. A configuration read shifts the device's own 48 bits out first, followed by whatever arrives on the return line. The return line carries the upper devices' bytes. Two poll commands report a chain-wide wired-AND of the local busy or interrupt flag. Depending on a configuration bit, the status is given as a level or as a toggling line.

Top module: `chain_spi_slave`

## Requirements
- R1: `csb_up_o` and `sck_up_o` always equal `csb_i` and `sck_i`.
- R2: After reset `cfg_o` is zero. While chip select is high, `sdo_o` and `sdi_up_o` are 1.
- R3: The first eight bits after chip select falls form the command, sampled on rising edges, most significant bit first. Codes: 0x01 write, 0x02 read, 0x07 busy poll, 0x08 interrupt poll. Each command bit is repeated on `sdi_up_o` from the falling edge that follows its rising edge.
- R4: During a write, `sdo_o` stays 1. When chip select rises, `cfg_o` takes the last 48 data bits received, the first of them at bit 47.
- R5: During a write, `sdi_up_o` shows 1 for the first 47 falling edges after the command. After that it shows each data bit exactly 48 bit periods after it arrived.
- R6: On a read, `sdo_o` presents `cfg_o` from bit 47 downward, starting at the first falling edge after the command. After that it presents each return-line bit exactly 48 bit periods after it was sampled.
- R7: Level polling is selected when `cfg_o[43]` is 1 (bit 3 of the first byte). In level polling, `sdo_o` is 0 while the polled local flag is 1 or the return line is 0, and 1 otherwise.
- R8: Toggle polling is selected when `cfg_o[43]` is 0. In toggle polling, `sdo_o` inverts at each falling edge if the local flag is 1, or if the return line differed at the last rising edge from its value at the rising edge before. Otherwise `sdo_o` holds.
- R9: When `top_strap_i` is 1, the return line is ignored: reads shift in ones and level polling treats the line as high. `sdi_up_o` stays 1 in that case.
- R10: Any other command code is ignored for the rest of the frame. `sdo_o` stays 1 and `cfg_o` is unchanged.
- R11: A write frame that ends with fewer than 48 data bits leaves `cfg_o` unchanged.
- R12: When chip select rises during a poll, `sdo_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| top_strap_i | input | 1 | High on the topmost device of the chain |
| csb_i | input | 1 | Chip select from below, active low |
| sck_i | input | 1 | Serial clock from below, idles high |
| sdi_i | input | 1 | Serial data from below |
| sdo_o | output | 1 | Serial data toward the host |
| csb_up_o | output | 1 | Chip select repeated upward |
| sck_up_o | output | 1 | Serial clock repeated upward |
| sdi_up_o | output | 1 | Serial data forwarded upward |
| sdo_ret_i | input | 1 | Data out of the device above |
| busy_i | input | 1 | Local conversion-busy flag |
| irq_i | input | 1 | Local interrupt flag |
| cfg_o | output | 48 | Own configuration bytes, first byte in bits 47:40 |

## Verification
The hardest condition to reach from the pins is toggle polling driven only by the device above, because that path depends on a rising-edge history of the return line. The stimulus gets there in steps. It first writes a configuration with the level bit clear and polls with the local interrupt set. It then drops the interrupt and confirms that the line holds. Finally, it flips the return line at chosen bit periods so that the one-bit lag of the upward toggle can be compared against the model. The 48-bit forwarding delay is covered by a two-device write stream, and the read delay by a return-line pattern that runs past the device's own bytes.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_POLL,
    ST_SKIP
  } st_t;
endpackage

// File: rtl/chain_pin_sync.sv
module chain_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/chain_cfg_shift.sv
module chain_cfg_shift #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ones_i,
  input  logic         load_cfg_i,
  input  logic         shift_en_i,
  input  logic         shift_bit_i,
  input  logic         commit_i,
  output logic         msb_o,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] sr;
  logic [W-1:0] cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '1;
      cfg <= '0;
    end else begin
      if (load_ones_i)     sr <= '1;
      else if (load_cfg_i) sr <= cfg;
      else if (shift_en_i) sr <= {sr[W-2:0], shift_bit_i};
      if (commit_i) cfg <= sr;
    end
  end

  assign msb_o = sr[W-1];
  assign cfg_o = cfg;
endmodule

// File: rtl/chain_poll_unit.sv
module chain_poll_unit (
  input  logic top_i,
  input  logic busy_i,
  input  logic irq_i,
  input  logic irq_sel_i,
  input  logic ret_lvl_i,
  input  logic ret_chg_i,
  output logic local_o,
  output logic level_o,
  output logic tog_o
);
  always_comb begin
    local_o = irq_sel_i ? irq_i : busy_i;
    level_o = ~local_o & (top_i | ret_lvl_i);
    tog_o   = local_o | (~top_i & ret_chg_i);
  end
endmodule

// File: rtl/chain_spi_slave.sv
module chain_spi_slave
  import chain_spi_pkg::*;
#(
  parameter int         CFG_BYTES   = 6,
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_W       = 12,
  parameter int         LVL_BYTE    = 0,
  parameter int         LVL_BIT     = 3,
  parameter logic [7:0] CMD_WR      = 8'h01,
  parameter logic [7:0] CMD_RD      = 8'h02,
  parameter logic [7:0] CMD_PBUSY   = 8'h07,
  parameter logic [7:0] CMD_PIRQ    = 8'h08
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   top_strap_i,
  input  logic                   csb_i,
  input  logic                   sck_i,
  input  logic                   sdi_i,
  output logic                   sdo_o,
  output logic                   csb_up_o,
  output logic                   sck_up_o,
  output logic                   sdi_up_o,
  input  logic                   sdo_ret_i,
  input  logic                   busy_i,
  input  logic                   irq_i,
  output logic [CFG_BYTES*8-1:0] cfg_o
);
  localparam int CFG_W    = CFG_BYTES * 8;
  localparam int LVL_IDX  = CFG_W - 1 - 8 * LVL_BYTE - (7 - LVL_BIT);
  localparam int DONE_CNT = CMD_W + CFG_W;

  // pin synchronizer: {csb, sck, sdi, ret}
  logic [3:0] sv;
  logic s_csb, s_sck, s_sdi, s_ret;
  chain_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({csb_i, sck_i, sdi_i, sdo_ret_i}),
    .q_o(sv)
  );
  assign {s_csb, s_sck, s_sdi, s_ret} = sv;

  logic p_csb, p_sck;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_csb <= 1'b1;
      p_sck <= 1'b1;
    end else begin
      p_csb <= s_csb;
      p_sck <= s_sck;
    end
  end

  logic sck_rise, sck_fall, csb_rise;
  assign sck_rise = s_sck & ~p_sck & ~s_csb;
  assign sck_fall = ~s_sck & p_sck & ~s_csb;
  assign csb_rise = s_csb & ~p_csb;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_sr;
  logic             irq_sel;
  logic             sdo_q, up_q;
  logic             ret_prev, ret_chg;

  logic [CMD_W-1:0] cmd_next;
  logic             cmd_done;
  st_t              dec_st;
  assign cmd_next = {cmd_sr[CMD_W-2:0], s_sdi};
  assign cmd_done = sck_rise && (st == ST_CMD) && (cnt == CNT_W'(CMD_W - 1));

  always_comb begin
    unique case (cmd_next)
      CMD_WR:              dec_st = ST_WR;
      CMD_RD:              dec_st = ST_RD;
      CMD_PBUSY, CMD_PIRQ: dec_st = ST_POLL;
      default:             dec_st = ST_SKIP;
    endcase
  end

  // configuration shift register and committed bytes
  logic sr_msb, commit, shift_bit;
  assign commit    = csb_rise && (st == ST_WR) && (cnt >= CNT_W'(DONE_CNT));
  assign shift_bit = (st == ST_WR) ? s_sdi : (top_strap_i | s_ret);

  chain_cfg_shift #(.W(CFG_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_ones_i(cmd_done && dec_st == ST_WR),
    .load_cfg_i (cmd_done && dec_st == ST_RD),
    .shift_en_i (sck_rise && (st == ST_WR || st == ST_RD)),
    .shift_bit_i(shift_bit),
    .commit_i   (commit),
    .msb_o      (sr_msb),
    .cfg_o      (cfg_o)
  );

  // polling status
  logic lvl_mode, poll_local, poll_level, poll_tog;
  assign lvl_mode = cfg_o[LVL_IDX];

  chain_poll_unit u_poll (
    .top_i(top_strap_i), .busy_i(busy_i), .irq_i(irq_i),
    .irq_sel_i(irq_sel), .ret_lvl_i(s_ret), .ret_chg_i(ret_chg),
    .local_o(poll_local), .level_o(poll_level), .tog_o(poll_tog)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cmd_sr   <= '1;
      irq_sel  <= 1'b0;
      sdo_q    <= 1'b1;
      up_q     <= 1'b1;
      ret_prev <= 1'b1;
      ret_chg  <= 1'b0;
    end else if (s_csb) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cmd_sr   <= '1;
      sdo_q    <= 1'b1;
      up_q     <= 1'b1;
      ret_prev <= 1'b1;
      ret_chg  <= 1'b0;
    end else begin
      if (st == ST_IDLE) st <= ST_CMD;

      if (sck_rise) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        ret_prev <= s_ret;
        ret_chg  <= (s_ret != ret_prev);
        if (st == ST_CMD) cmd_sr <= cmd_next;
        if (cmd_done) begin
          st      <= dec_st;
          irq_sel <= (cmd_next == CMD_PIRQ);
        end
      end

      if (sck_fall) begin
        if (top_strap_i)                      up_q <= 1'b1;
        else if (cnt <= CNT_W'(CMD_W))        up_q <= cmd_sr[0];
        else if (st == ST_WR)                 up_q <= sr_msb;
        else                                  up_q <= 1'b1;

        if (st == ST_RD)                      sdo_q <= sr_msb;
        else if (st == ST_POLL && !lvl_mode && poll_tog) sdo_q <= ~sdo_q;
      end

      if (st == ST_POLL && lvl_mode) sdo_q <= poll_level;
    end
  end

  assign sdo_o    = sdo_q;
  assign sdi_up_o = up_q;
  assign csb_up_o = csb_i;
  assign sck_up_o = sck_i;
endmodule

// File: rtl/chain_spi_slave_chk.sv
module chain_spi_slave_chk
  import chain_spi_pkg::*;
#(
  parameter int CFG_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             top_i,
  input logic             sdo_i,
  input logic             up_i,
  input logic [CFG_W-1:0] cfg_i,
  input st_t              st_i,
  input logic             lvl_i,
  input logic             local_i,
  input logic             commit_i,
  input logic             s_csb_i
);
  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_csb_i) |-> (sdo_i && up_i)); // R2

  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_i) |-> $stable(cfg_i)); // R10

  AST_LEVEL_LOW_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_i == ST_POLL && lvl_i && local_i) && st_i == ST_POLL) |-> !sdo_i); // R7

  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_i == ST_POLL && !lvl_i && !local_i && top_i) && st_i == ST_POLL)
      |-> $stable(sdo_i)); // R8

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == ST_SKIP && $past(st_i == ST_SKIP)) |-> sdo_i); // R10

  AST_TOP_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(top_i) && top_i && st_i == ST_WR && $past(st_i == ST_WR)) |-> up_i); // R9
endmodule

bind chain_spi_slave chain_spi_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .top_i(top_strap_i), .sdo_i(sdo_o),
  .up_i(sdi_up_o), .cfg_i(cfg_o), .st_i(st), .lvl_i(lvl_mode),
  .local_i(poll_local), .commit_i(commit), .s_csb_i(s_csb)
);

// File: tb/chain_spi_slave_test.sv
module chain_spi_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic top = 1'b0, csb = 1'b1, sck = 1'b1, sdi = 1'b1, ret = 1'b1;
  logic busy = 1'b0, irq = 1'b0;
  logic sdo, csb_up, sck_up, sdi_up;
  logic [47:0] cfg;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  chain_spi_slave uut (
    .clk(clk), .rst_n(rst_n), .top_strap_i(top), .csb_i(csb), .sck_i(sck),
    .sdi_i(sdi), .sdo_o(sdo), .csb_up_o(csb_up), .sck_up_o(sck_up),
    .sdi_up_o(sdi_up), .sdo_ret_i(ret), .busy_i(busy), .irq_i(irq),
    .cfg_o(cfg)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic din, input logic r, output logic dout,
                         output logic upo);
    @(negedge clk);
    sck = 1'b0; sdi = din; ret = r;
    repeat (HALF) @(negedge clk);
    dout = sdo; upo = sdi_up;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_open();
    @(negedge clk);
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_close();
    @(negedge clk);
    csb = 1'b1; ret = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic d, u;
    for (int k = 1; k <= 8; k++) begin
      spi_bit(c[8-k], 1'b1, d, u);
      check(d == 1'b1, "R2 sdo high during command", d, 1);
      if (k >= 2)
        check(u == (top ? 1'b1 : c[9-k]), "R3 command forwarded", u, c[9-k]);
    end
  endtask

  // write frame: command, then nbits taken from data[95] downward
  task automatic do_write(input logic [7:0] c, input int nbits,
                          input logic [95:0] data, input bit chk_up);
    logic d, u, din;
    logic upq[$];
    for (int i = 0; i < 47; i++) upq.push_back(1'b1);
    frame_open();
    send_cmd(c);
    for (int i = 0; i < nbits; i++) begin
      din = data[95-i];
      spi_bit(din, 1'b1, d, u);
      check(d == 1'b1, "R4 R10 sdo high during write or skip", d, 1);
      if (top) check(u == 1'b1, "R9 top does not forward", u, 1);
      else if (i == 0) check(u == c[0], "R3 last command bit forwarded", u, c[0]);
      else if (chk_up) begin
        logic e;
        e = upq.pop_front();
        check(u == e, "R5 forwarded data delayed 48", u, e);
      end
      upq.push_back(din);
    end
    frame_close();
  endtask

  task automatic do_read(input int nbits, input logic [47:0] exp_cfg);
    logic d, u, r, e;
    logic q[$];
    for (int i = 47; i >= 0; i--) q.push_back(exp_cfg[i]);
    frame_open();
    send_cmd(8'h02);
    for (int i = 0; i < nbits; i++) begin
      r = ((i % 3) == 1);
      spi_bit(1'b0, r, d, u);
      e = q.pop_front();
      check(d == e, top ? "R6 R9 read data" : "R6 read data", d, e);
      q.push_back(top ? 1'b1 : r);
    end
    frame_close();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [47:0] top_bytes = 48'h1234_5678_9ABC;
    logic [47:0] own_a     = 48'h5AC3_0F96_E17B; // level bit set
    logic [47:0] own_b     = 48'h5000_0000_0011; // level bit clear
    logic d, u, e, r1, r2, rv;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cfg == 48'h0, "R2 reset cfg", cfg, 0);
    check(sdo == 1'b1 && sdi_up == 1'b1, "R2 idle lines", {sdo, sdi_up}, 3);
    check(csb_up == 1'b1 && sck_up == 1'b1, "R1 pass idle", {csb_up, sck_up}, 3);
    csb = 1'b0; sck = 1'b0; #1;
    check(csb_up == 1'b0 && sck_up == 1'b0, "R1 pass low", {csb_up, sck_up}, 0);
    @(negedge clk); csb = 1'b1; sck = 1'b1;
    repeat (2 * HALF) @(negedge clk);

    // two-device write stream, top bytes first
    do_write(8'h01, 96, {top_bytes, own_a}, 1'b1);
    check(cfg == own_a, "R4 keeps last 48 bits", cfg, own_a);

    do_read(48 + 20, own_a);
    check(cfg == own_a, "R6 read leaves cfg", cfg, own_a);

    do_write(8'h5A, 48, {own_b, 48'h0}, 1'b0);
    check(cfg == own_a, "R10 unknown command ignored", cfg, own_a);

    do_write(8'h01, 40, {own_b, 48'h0}, 1'b0);
    check(cfg == own_a, "R11 short write no commit", cfg, own_a);

    // level polling (cfg bit 43 = 1)
    frame_open();
    send_cmd(8'h07);
    @(negedge clk); busy = 1'b0; ret = 1'b1;
    repeat (HALF) @(negedge clk);
    check(sdo == 1'b1, "R7 level idle chain", sdo, 1);
    busy = 1'b1; repeat (HALF) @(negedge clk);
    check(sdo == 1'b0, "R7 level local busy", sdo, 0);
    busy = 1'b0; ret = 1'b0; repeat (HALF) @(negedge clk);
    check(sdo == 1'b0, "R7 level upper busy", sdo, 0);
    ret = 1'b1; repeat (HALF) @(negedge clk);
    check(sdo == 1'b1, "R7 level all clear", sdo, 1);
    busy = 1'b1; repeat (HALF) @(negedge clk);
    frame_close();
    check(sdo == 1'b1, "R12 poll ends at chip select high", sdo, 1);
    busy = 1'b0;

    frame_open();
    send_cmd(8'h08);
    @(negedge clk); irq = 1'b1; busy = 1'b0;
    repeat (HALF) @(negedge clk);
    check(sdo == 1'b0, "R7 level interrupt", sdo, 0);
    irq = 1'b0; busy = 1'b1; repeat (HALF) @(negedge clk);
    check(sdo == 1'b1, "R7 interrupt poll ignores busy", sdo, 1);
    frame_close();
    busy = 1'b0;

    // top of stack
    top = 1'b1;
    repeat (HALF) @(negedge clk);
    frame_open();
    send_cmd(8'h07);
    @(negedge clk); ret = 1'b0;
    repeat (HALF) @(negedge clk);
    check(sdo == 1'b1, "R9 top ignores return line", sdo, 1);
    frame_close();
    do_read(48 + 8, own_a);
    do_write(8'h01, 48, {own_a, 48'h0}, 1'b1);
    top = 1'b0;

    // toggle polling (cfg bit 43 = 0)
    do_write(8'h01, 48, {own_b, 48'h0}, 1'b1);
    check(cfg == own_b, "R4 single-device write", cfg, own_b);
    frame_open();
    send_cmd(8'h08);
    e = 1'b1; r1 = 1'b1; r2 = 1'b1;
    for (int j = 9; j < 30; j++) begin
      @(negedge clk);
      irq = (j < 15);
      rv  = (j >= 19 && j < 25) ? j[0] : 1'b1;
      if (irq || (r1 != r2)) e = ~e;
      spi_bit(1'b0, rv, d, u);
      check(d == e, "R8 toggle polling", d, e);
      r2 = r1; r1 = rv;
    end
    frame_close();
    check(sdo == 1'b1, "R12 toggle poll ends high", sdo, 1);
    irq = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule